// File: doc/BRIEF.md
# Serial Port FIFO Control Unit

This block holds the transmit and receive byte queues of one serial channel together with the 32-bit control word that governs them. Host software writes the control word over a simple register port and reads it back at any time. The host pushes bytes into the transmit queue and the serializer drains them. The deserializer fills the receive queue and the host drains it.

Each direction raises a request line for DMA or interrupt logic. The receive request follows the number of stored bytes. The transmit request follows the number of free slots. Each direction has its own coded threshold. Each queue can be flushed by software, but only while a separate enable bit is also set, and the flush lasts until software clears its bit. A self-clearing channel reset bit reinitializes the control word and drives a reset strobe to the rest of the channel for a fixed number of cycles. It leaves both queues untouched.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: After rst_ni is released, the control word reads 0, both queues are empty, rx_req_o is low and tx_req_o is high.
- R2: A register write stores wdata bits 8:7 (receive threshold code), 4:3 (transmit threshold code), 2 (transmit flush), 1 (receive flush) and 0 (flush enable), and these take effect in the next cycle. Bits 31:16, 14:9 and 6:5 always read 0.
- R3: Each queue holds 16 bytes in first-in first-out order and shows its oldest byte at the read data output. A push to a full queue and a pop from an empty queue are ignored. The full and empty flags follow the occupancy.
- R4: Bit 2 flushes the transmit queue and bit 1 flushes the receive queue, but only while bit 0 is also 1. Without bit 0 the stored bytes stay in place.
- R5: While a flush is in force, its queue is emptied in the next cycle and stays empty, and pushes and pops are ignored. This lasts until software writes the flush bit or the enable bit back to 0.
- R6: rx_req_o is high while the receive occupancy is at least 1, 4, 8 or 12 bytes for threshold codes 00, 01, 10 and 11.
- R7: tx_req_o is high while the free transmit space is at least 1, 4 or 8 bytes for codes 00, 01 and 10. With code 11, tx_req_o is held low.
- R8: Writing 1 to bit 15 clears the control word to 0. Bit 15 and chan_rst_o then read 1 for exactly 4 cycles and return to 0 by themselves.
- R9: While the channel reset runs, register writes are ignored. Both queues keep their contents and go on accepting pushes and pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| tx_wr_i | input | 1 | Host push into transmit queue |
| tx_wdata_i | input | 8 | Byte to push into transmit queue |
| tx_rd_i | input | 1 | Serializer pop from transmit queue |
| tx_rdata_o | output | 8 | Oldest transmit byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_wr_i | input | 1 | Deserializer push into receive queue |
| rx_wdata_i | input | 8 | Byte to push into receive queue |
| rx_rd_i | input | 1 | Host pop from receive queue |
| rx_rdata_o | output | 8 | Oldest receive byte |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_req_o | output | 1 | Transmit space request |
| rx_req_o | output | 1 | Receive data request |
| chan_rst_o | output | 1 | Reset strobe to the rest of the channel |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flush in force and a push into the same queue. The second pair is the start of the channel reset and queue traffic. The bench provokes the first pair by driving pushes on every cycle while the flush and enable bits are set. It provokes the second pair by writing bit 15 in the same cycle as a push and a pop, and then issuing register writes while the reset runs. A behavioural queue model is compared against every output on every cycle. It must show that flushed pushes vanish, that traffic during the channel reset lands normally, and that the ignored writes leave the control word at 0.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;
  localparam int CTRL_W    = 32;
  localparam int SRST_BIT  = 15;
  localparam int RXL_LO    = 7;
  localparam int TXL_LO    = 3;
  localparam int TXCLR_BIT = 2;
  localparam int RXCLR_BIT = 1;
  localparam int CLREN_BIT = 0;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  typedef struct packed {
    logic [1:0] rx_lvl;
    logic [1:0] tx_lvl;
    logic       tx_clr;
    logic       rx_clr;
    logic       clr_en;
  } ctrl_t;

  function automatic int rx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 12;
    endcase
  endfunction

  // code 11 is disallowed for transmit; caller gates it
  function automatic int tx_thresh(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
  import sio_fifo_pkg::*;
#(
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              busy_o,
  output logic [CTRL_W-1:0] rdata_o
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;          // writes ignored while sequencing
    end else if (we_i) begin
      if (wdata_i[SRST_BIT]) begin
        ctrl_q <= '0;
        cnt_q  <= CNT_W'(SRST_CYCLES);
      end else begin
        ctrl_q.rx_lvl <= wdata_i[RXL_LO+1:RXL_LO];
        ctrl_q.tx_lvl <= wdata_i[TXL_LO+1:TXL_LO];
        ctrl_q.tx_clr <= wdata_i[TXCLR_BIT];
        ctrl_q.rx_clr <= wdata_i[RXCLR_BIT];
        ctrl_q.clr_en <= wdata_i[CLREN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[SRST_BIT]             = busy_o;
    rdata_o[RXL_LO+1:RXL_LO]      = ctrl_q.rx_lvl;
    rdata_o[TXL_LO+1:TXL_LO]      = ctrl_q.tx_lvl;
    rdata_o[TXCLR_BIT]            = ctrl_q.tx_clr;
    rdata_o[RXCLR_BIT]            = ctrl_q.rx_clr;
    rdata_o[CLREN_BIT]            = ctrl_q.clr_en;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       empty_o,
  output logic                       full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/sio_req_gen.sv
module sio_req_gen
  import sio_fifo_pkg::*;
#(
  parameter int   DEPTH = 16,
  parameter dir_e DIR   = DIR_RX
) (
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic [1:0]                 code_i,
  output logic                       req_o
);
  generate
    if (DIR == DIR_TX) begin : g_tx
      int free;
      always_comb begin
        free  = DEPTH - int'(count_i);
        req_o = (code_i != 2'b11) && (free >= tx_thresh(code_i));
      end
    end else begin : g_rx
      always_comb req_o = int'(count_i) >= rx_thresh(code_i);
    end
  endgenerate
endmodule

// File: rtl/sio_fifo_ctrl.sv
module sio_fifo_ctrl
  import sio_fifo_pkg::*;
#(
  parameter int W           = 8,
  parameter int DEPTH       = 16,
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_wdata_i,
  input  logic        tx_rd_i,
  output logic [7:0]  tx_rdata_o,
  output logic        tx_empty_o,
  output logic        tx_full_o,
  input  logic        rx_wr_i,
  input  logic [7:0]  rx_wdata_i,
  input  logic        rx_rd_i,
  output logic [7:0]  rx_rdata_o,
  output logic        rx_empty_o,
  output logic        rx_full_o,
  output logic        tx_req_o,
  output logic        rx_req_o,
  output logic        chan_rst_o
);
  localparam int CW = $clog2(DEPTH + 1);

  ctrl_t         ctrl;
  logic          busy;
  logic          tx_clr_act, rx_clr_act;
  logic [CW-1:0] tx_cnt, rx_cnt;

  sio_ctrl_reg #(.SRST_CYCLES(SRST_CYCLES)) u_reg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .busy_o(busy), .rdata_o(reg_rdata_o)
  );

  assign tx_clr_act = ctrl.clr_en && ctrl.tx_clr;
  assign rx_clr_act = ctrl.clr_en && ctrl.rx_clr;
  assign chan_rst_o = busy;

  sio_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr_act), .push_i(tx_wr_i), .din_i(tx_wdata_i),
    .pop_i(tx_rd_i), .dout_o(tx_rdata_o), .count_o(tx_cnt),
    .empty_o(tx_empty_o), .full_o(tx_full_o)
  );

  sio_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr_act), .push_i(rx_wr_i), .din_i(rx_wdata_i),
    .pop_i(rx_rd_i), .dout_o(rx_rdata_o), .count_o(rx_cnt),
    .empty_o(rx_empty_o), .full_o(rx_full_o)
  );

  sio_req_gen #(.DEPTH(DEPTH), .DIR(DIR_TX)) u_tx_req (
    .count_i(tx_cnt), .code_i(ctrl.tx_lvl), .req_o(tx_req_o)
  );

  sio_req_gen #(.DEPTH(DEPTH), .DIR(DIR_RX)) u_rx_req (
    .count_i(rx_cnt), .code_i(ctrl.rx_lvl), .req_o(rx_req_o)
  );
endmodule

// File: rtl/sio_fifo_ctrl_chk.sv
module sio_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [31:0]   reg_rdata_o,
  input logic          tx_rd_i,
  input logic          rx_rd_i,
  input logic          tx_empty_o,
  input logic          rx_empty_o,
  input logic          tx_req_o,
  input logic          rx_req_o,
  input logic          chan_rst_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_gate_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[0] && !tx_rd_i) |=> (tx_cnt >= $past(tx_cnt)));

  p_gate_rx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[0] && !rx_rd_i) |=> (rx_cnt >= $past(rx_cnt)));

  p_flush_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && reg_rdata_o[2]) |=> tx_empty_o);

  p_flush_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && reg_rdata_o[1]) |=> rx_empty_o);

  p_rx_req_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_req_o);

  p_tx_code3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[4:3] == 2'b11) |-> !tx_req_o);

  p_srst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_rst_o) |-> (reg_rdata_o[14:0] == 15'd0));

  p_srst_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_rst_o) |=> (chan_rst_o && reg_rdata_o[15]));

  p_srst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |=> $stable(reg_rdata_o[14:0]));

  p_fifo_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o && !tx_rd_i) |=> (tx_cnt >= $past(tx_cnt)));
endmodule

bind sio_fifo_ctrl sio_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_rdata_o(reg_rdata_o),
  .tx_rd_i(tx_rd_i), .rx_rd_i(rx_rd_i),
  .tx_empty_o(tx_empty_o), .rx_empty_o(rx_empty_o),
  .tx_req_o(tx_req_o), .rx_req_o(rx_req_o), .chan_rst_o(chan_rst_o),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sio_fifo_ctrl_tb.sv
module sio_fifo_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_wr = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0]  tx_wdata = '0, rx_wdata = '0;
  logic [7:0]  tx_rdata, rx_rdata;
  logic        tx_empty, tx_full, rx_empty, rx_full, tx_req, rx_req, chan_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_fifo_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .tx_rd_i(tx_rd),
    .tx_rdata_o(tx_rdata), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_wr_i(rx_wr), .rx_wdata_i(rx_wdata), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .rx_empty_o(rx_empty), .rx_full_o(rx_full), .tx_req_o(tx_req), .rx_req_o(rx_req),
    .chan_rst_o(chan_rst)
  );

  // behavioural reference
  bit [7:0] tx_q[$];
  bit [7:0] rx_q[$];
  bit       m_en, m_txc, m_rxc;
  bit [1:0] m_txl, m_rxl;
  int       m_busy;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q.delete(); rx_q.delete();
      m_en = 0; m_txc = 0; m_rxc = 0; m_txl = 0; m_rxl = 0; m_busy = 0;
    end else begin
      if (m_en && m_txc) tx_q.delete();
      else begin
        bit dp, dw;
        dp = tx_rd && tx_q.size() > 0;
        dw = tx_wr && tx_q.size() < 16;
        if (dp) void'(tx_q.pop_front());
        if (dw) tx_q.push_back(tx_wdata);
      end
      if (m_en && m_rxc) rx_q.delete();
      else begin
        bit dp, dw;
        dp = rx_rd && rx_q.size() > 0;
        dw = rx_wr && rx_q.size() < 16;
        if (dp) void'(rx_q.pop_front());
        if (dw) rx_q.push_back(rx_wdata);
      end
      if (m_busy > 0) m_busy--;
      else if (reg_we) begin
        if (reg_wdata[15]) begin
          m_en = 0; m_txc = 0; m_rxc = 0; m_txl = 0; m_rxl = 0; m_busy = 4;
        end else begin
          m_rxl = reg_wdata[8:7]; m_txl = reg_wdata[4:3];
          m_txc = reg_wdata[2]; m_rxc = reg_wdata[1]; m_en = reg_wdata[0];
        end
      end
    end
  end

  function automatic int rx_level(bit [1:0] c);
    int t[4] = '{1, 4, 8, 12};
    return t[c];
  endfunction

  function automatic int tx_level(bit [1:0] c);
    int t[4] = '{1, 4, 8, 0};
    return t[c];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] er;
    bit          etx_req;
    er = '0;
    er[15] = (m_busy > 0);
    er[8:7] = m_rxl; er[4:3] = m_txl;
    er[2] = m_txc; er[1] = m_rxc; er[0] = m_en;
    chk("R2/R8 ctrl word", reg_rdata, er);
    chk("R8 chan_rst", 32'(chan_rst), 32'(m_busy > 0));
    chk("R3 tx_empty", 32'(tx_empty), 32'(tx_q.size() == 0));
    chk("R3 tx_full", 32'(tx_full), 32'(tx_q.size() == 16));
    chk("R3 rx_empty", 32'(rx_empty), 32'(rx_q.size() == 0));
    chk("R3 rx_full", 32'(rx_full), 32'(rx_q.size() == 16));
    if (tx_q.size() > 0) chk("R3 tx head", 32'(tx_rdata), 32'(tx_q[0]));
    if (rx_q.size() > 0) chk("R3 rx head", 32'(rx_rdata), 32'(rx_q[0]));
    chk("R6 rx_req", 32'(rx_req), 32'(rx_q.size() >= rx_level(m_rxl)));
    etx_req = (m_txl != 2'b11) && ((16 - tx_q.size()) >= tx_level(m_txl));
    chk("R7 tx_req", 32'(tx_req), 32'(etx_req));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    reg_we = 0; tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0;
  endtask

  task automatic wr_reg(logic [31:0] d);
    reg_we = 1; reg_wdata = d; tick();
  endtask

  task automatic push_both(int n, int seed);
    for (int i = 0; i < n; i++) begin
      tx_wr = 1; tx_wdata = 8'(seed + i);
      rx_wr = 1; rx_wdata = 8'(seed * 3 + i * 7);
      tick();
    end
  endtask

  task automatic pop_both(int n);
    for (int i = 0; i < n; i++) begin
      tx_rd = 1; rx_rd = 1; tick();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ctrl", reg_rdata, 32'h0);
    chk("R1 empty", 32'({tx_empty, rx_empty}), 32'h3);
    chk("R1 reqs", 32'({tx_req, rx_req}), 32'h2);

    // R3 fill past capacity, then drain past empty
    push_both(18, 8'h10);
    pop_both(5);
    tx_wr = 1; tx_rd = 1; tx_wdata = 8'hA5; rx_wr = 1; rx_rd = 1; rx_wdata = 8'h5A; tick();
    pop_both(14);

    // R2 layout with reserved bits set
    wr_reg(32'hFFFF_7E60 | 32'h0000_0198);
    chk("R2 reserved read zero", reg_rdata & 32'hFFFF_7E60, 32'h0);
    chk("R2 fields", reg_rdata, 32'h0000_0198);

    // R6 each receive code across an occupancy sweep
    for (int c = 0; c < 4; c++) begin
      wr_reg(32'(c) << 7);
      for (int k = 0; k < 16; k++) begin rx_wr = 1; rx_wdata = 8'(k); tick(); end
      for (int k = 0; k < 16; k++) begin rx_rd = 1; tick(); end
    end
    // R7 each transmit code across an occupancy sweep, code 11 held low
    for (int c = 0; c < 4; c++) begin
      wr_reg(32'(c) << 3);
      for (int k = 0; k < 16; k++) begin tx_wr = 1; tx_wdata = 8'(k + 40); tick(); end
      if (c == 3) chk("R7 code 11 low", 32'(tx_req), 32'h0);
      for (int k = 0; k < 16; k++) begin tx_rd = 1; tick(); end
    end
    wr_reg(32'h0);

    // R4 flush bits without enable do nothing
    push_both(6, 8'h60);
    wr_reg(32'h6);
    tick();
    chk("R4 tx kept without enable", 32'(tx_empty), 32'h0);
    chk("R4 rx kept without enable", 32'(rx_empty), 32'h0);
    // enable alone with no flush bit
    wr_reg(32'h1);
    chk("R4 enable alone keeps data", 32'({tx_empty, rx_empty}), 32'h0);

    // R5 transmit flush in force, pushes in the same cycles
    wr_reg(32'h5);
    for (int i = 0; i < 5; i++) begin
      tx_wr = 1; tx_wdata = 8'(i); rx_wr = 1; rx_wdata = 8'(i + 200); tick();
    end
    chk("R5 tx held empty", 32'(tx_empty), 32'h1);
    chk("R5 rx untouched", 32'(rx_empty), 32'h0);
    wr_reg(32'h1);
    push_both(3, 8'h70);
    chk("R5 tx released", 32'(tx_empty), 32'h0);
    wr_reg(32'h3);
    rx_wr = 1; rx_wdata = 8'hEE; tick();
    chk("R5 rx held empty", 32'(rx_empty), 32'h1);
    wr_reg(32'h2);
    rx_wr = 1; rx_wdata = 8'hEF; tick();
    chk("R5 rx released by enable clear", 32'(rx_empty), 32'h0);

    // R8 / R9 channel reset with traffic in the same cycle
    wr_reg(32'h0000_0091);
    push_both(4, 8'h80);
    reg_we = 1; reg_wdata = 32'h0000_8000; tx_wr = 1; tx_wdata = 8'hC3; rx_rd = 1; tick();
    chk("R8 busy set", reg_rdata, 32'h0000_8000);
    reg_we = 1; reg_wdata = 32'h0000_019F; tick();
    chk("R9 write ignored", reg_rdata, 32'h0000_8000);
    reg_we = 1; reg_wdata = 32'h0000_8000; tx_rd = 1; rx_wr = 1; rx_wdata = 8'h3C; tick();
    tick();
    chk("R8 still busy in 4th cycle", 32'(chan_rst), 32'h1);
    tick();
    chk("R8 self clears", reg_rdata, 32'h0);
    chk("R9 tx kept", 32'(tx_empty), 32'h0);
    pop_both(16);

    // flush and channel reset together: reset clears the flush bits
    push_both(2, 8'h90);
    wr_reg(32'h7);
    reg_we = 1; reg_wdata = 32'h0000_8000; tx_wr = 1; tx_wdata = 8'h11; tick();
    repeat (5) tick();
    chk("R8 fields cleared", reg_rdata, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule